// File: doc/BRIEF.md
# Buffer DMA Transfer Controller

This block moves bytes out of a byte-wide external SRAM buffer to a host processor and, on the same memory port, stores bytes that arrive from the disc-drive side. Host-bound reads use a 15-bit read address counter and a 12-bit transfer counter. Each byte is fetched into a one-byte holding latch and then offered to the host over an active-high request and active-low acknowledge handshake. Drive-side bytes use their own 15-bit write address counter. They always win arbitration for the memory port over host reads.

Each memory access is either 4 clocks (fast) or 12 clocks (slow). The read or write strobe is low for two clocks in the middle of the access. A transfer that ends by count sets a sticky completion status. A transfer armed with a zero count runs without limit until the host clears enable.

Top module: `buf_dma_ctrl`

## Requirements
- R1: After reset, `dreq_o` and `cmp_o` are low, and both `mem_oe_no` and `mem_we_no` are high.
- R2: During a host read access, `mem_addr_o` carries the read address counter and stays unchanged while a strobe is low. The counter advances by one per byte fetched and wraps from 0x7FFF to 0x0000.
- R3: Control register (select 3): bit 7 is enable, bit 6 is fast mode, bits 3:0 are the transfer count bits 11:8. Select 2 loads count bits 7:0. With a nonzero count N at enable, exactly N bytes are delivered. Then `cmp_o` goes high and `dreq_o` stays low.
- R4: If the count is zero when enable rises, the transfer is unbounded. Bytes keep coming until the host writes enable low. `cmp_o` stays low, and `dreq_o` is low from the second clock after the write.
- R5: `dreq_o` is low in the clock after `dack_ni` is sampled low. A byte counts as delivered when `dack_ni` rises. `hdata_oe_o` is high, with the byte on `hdata_o`, while `dack_ni` and `rd_ni` are both low.
- R6: A host read in fast mode drives `mem_oe_no` low in clocks 1 and 2 of a 4-clock access. In slow mode it is low in clocks 5 and 6 of a 12-clock access. From the enable write to `dreq_o` high takes 6 clocks in fast mode and 14 clocks in slow mode.
- R7: Each pulse on `drv_valid_i` stores `drv_data_i` at the drive write address counter, with `mem_we_no` low for two clocks. The counter then advances by one. It is loaded by selects 4 (bits 7:0) and 5 (bits 14:8).
- R8: When a drive byte and a host read both wait for an idle memory port, the write goes first. The two strobes are never low together. No drive byte is lost if drive bytes are at least 24 clocks apart.
- R9: Writes to the address and count selects (0, 1, 2, 4, 5 and the count field of 3) are ignored while a transfer is enabled or a host read is in flight.
- R10: Writing select 6 with bit 0 set clears `cmp_o`. A rising enable also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| dreq_o | output | 1 | Host data request, active high |
| dack_ni | input | 1 | Host acknowledge, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| hdata_o | output | 8 | Byte offered to the host |
| hdata_oe_o | output | 1 | Host data drive enable |
| cmp_o | output | 1 | Sticky transfer-complete status |
| drv_valid_i | input | 1 | Drive byte valid pulse |
| drv_data_i | input | 8 | Drive byte |
| mem_addr_o | output | 15 | SRAM address |
| mem_oe_no | output | 1 | SRAM output enable, active low |
| mem_we_no | output | 1 | SRAM write strobe, active low |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_rdata_i | input | 8 | SRAM read data |

## Verification
The bench starts a bounded read just below the top of the address space. A counter that failed to wrap would return bytes from the wrong location, and a wrong count would deliver a byte too many or too few or never raise completion.

The bench also times the enable-to-request latency in both cycle lengths. A swapped or mis-decoded fast bit shows up as an 8-clock error.

An unbounded transfer runs while drive bytes arrive and while the host tries to reload the address. Dropped drive bytes, a reload that was not blocked, or a transfer that ended on its own all corrupt the byte stream or the later read-back.

A drive byte and a host enable arriving in the same clock must produce the write strobe first. Reversed priority would show the read strobe first.

// File: rtl/buf_dma_pkg.sv
package buf_dma_pkg;
  typedef enum logic [2:0] {
    SEL_HADDR_LO = 3'd0,
    SEL_HADDR_HI = 3'd1,
    SEL_CNT_LO   = 3'd2,
    SEL_CTRL     = 3'd3,
    SEL_DADDR_LO = 3'd4,
    SEL_DADDR_HI = 3'd5,
    SEL_STS      = 3'd6
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_FAST_BIT = 6;
  localparam int STS_CLR_BIT   = 0;
endpackage

// File: rtl/buf_dma_seq.sv
module buf_dma_seq #(
  parameter int AW       = 15,
  parameter int FAST_LEN = 4,
  parameter int SLOW_LEN = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_i,
  input  logic          drv_req_i,
  input  logic          host_req_i,
  input  logic [AW-1:0] drv_addr_i,
  input  logic [AW-1:0] host_addr_i,
  output logic          drv_gnt_o,
  output logic          host_gnt_o,
  output logic          rd_cap_o,
  output logic          rd_done_o,
  output logic          wr_done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_oe_no,
  output logic          mem_we_no
);
  localparam int PW = $clog2(SLOW_LEN);
  localparam logic [PW-1:0] F_LAST = PW'(FAST_LEN - 1);
  localparam logic [PW-1:0] S_LAST = PW'(SLOW_LEN - 1);
  localparam logic [PW-1:0] F_S0   = PW'(FAST_LEN / 2 - 1);
  localparam logic [PW-1:0] S_S0   = PW'(SLOW_LEN / 2 - 1);

  logic          busy_q, wr_q;
  logic [PW-1:0] ph_q, last_q, s0_q, s1_c;
  logic [AW-1:0] addr_q;
  logic          end_c, strobe_c;

  assign drv_gnt_o  = !busy_q && drv_req_i;
  assign host_gnt_o = !busy_q && !drv_req_i && host_req_i;

  assign s1_c     = s0_q + 1'b1;
  assign end_c    = busy_q && (ph_q == last_q);
  assign strobe_c = busy_q && (ph_q == s0_q || ph_q == s1_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      ph_q   <= '0;
      last_q <= S_LAST;
      s0_q   <= S_S0;
      addr_q <= '0;
    end else if (drv_gnt_o || host_gnt_o) begin
      busy_q <= 1'b1;
      wr_q   <= drv_gnt_o;
      ph_q   <= '0;
      last_q <= fast_i ? F_LAST : S_LAST;
      s0_q   <= fast_i ? F_S0 : S_S0;
      addr_q <= drv_gnt_o ? drv_addr_i : host_addr_i;
    end else if (busy_q) begin
      ph_q <= ph_q + 1'b1;
      if (end_c) busy_q <= 1'b0;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_oe_no  = !(strobe_c && !wr_q);
  assign mem_we_no  = !(strobe_c && wr_q);
  assign rd_cap_o   = busy_q && !wr_q && (ph_q == s1_c);
  assign rd_done_o  = end_c && !wr_q;
  assign wr_done_o  = end_c && wr_q;
endmodule

// File: rtl/buf_dma_drv.sv
module buf_dma_drv #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drv_valid_i,
  input  logic [DW-1:0] drv_data_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [7:0]    ld_data_i,
  input  logic          lock_i,
  input  logic          gnt_i,
  input  logic          done_i,
  output logic          pend_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          pend_q;
  logic [DW-1:0] data_q, hold_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
      hold_q <= '0;
      addr_q <= '0;
    end else begin
      // a new byte wins over the grant that empties the slot
      if (drv_valid_i) begin
        pend_q <= 1'b1;
        data_q <= drv_data_i;
      end else if (gnt_i) begin
        pend_q <= 1'b0;
      end
      if (gnt_i) hold_q <= data_q;
      if (done_i) begin
        addr_q <= addr_q + 1'b1;
      end else if (!lock_i) begin
        if (ld_lo_i) addr_q[7:0]    <= ld_data_i;
        if (ld_hi_i) addr_q[AW-1:8] <= ld_data_i[AW-9:0];
      end
    end
  end

  assign pend_o  = pend_q;
  assign addr_o  = addr_q;
  assign wdata_o = hold_q;
endmodule

// File: rtl/buf_dma_host.sv
module buf_dma_host
  import buf_dma_pkg::*;
#(
  parameter int AW = 15,
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          dack_ni,
  input  logic          rd_ni,
  input  logic          gnt_i,
  input  logic          cap_i,
  input  logic          done_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          want_o,
  output logic [AW-1:0] addr_o,
  output logic          fast_o,
  output logic          lock_o,
  output logic          dreq_o,
  output logic [DW-1:0] hdata_o,
  output logic          hdata_oe_o,
  output logic          cmp_o
);
  logic          en_q, fast_q, unb_q, full_q, infl_q, dreq_q, dack_q, cmp_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q, new_cnt_c;
  logic [DW-1:0] lat_q;
  logic          lock_c, wr_ctrl_c, en_rise_c, deliver_c, finish_c, sts_clr_c;
  reg_sel_e      sel_c;

  assign sel_c     = reg_sel_e'(reg_sel_i);
  assign lock_c    = en_q || infl_q;
  assign wr_ctrl_c = reg_we_i && sel_c == SEL_CTRL;
  assign en_rise_c = wr_ctrl_c && !lock_c && reg_wdata_i[CTRL_EN_BIT];
  assign sts_clr_c = reg_we_i && sel_c == SEL_STS && reg_wdata_i[STS_CLR_BIT];
  assign new_cnt_c = {reg_wdata_i[CW-9:0], cnt_q[7:0]};
  assign deliver_c = !dack_q && dack_ni && full_q;
  assign finish_c  = en_q && !unb_q && cnt_q == '0 && !full_q && !infl_q;
  assign want_o    = en_q && !full_q && !infl_q && (unb_q || cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fast_q <= 1'b0;
      unb_q  <= 1'b0;
      full_q <= 1'b0;
      infl_q <= 1'b0;
      dreq_q <= 1'b0;
      dack_q <= 1'b1;
      cmp_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else begin
      dack_q <= dack_ni;
      if (gnt_i) infl_q <= 1'b1;
      else if (done_i) infl_q <= 1'b0;
      if (cap_i) lat_q <= mem_rdata_i;

      if (done_i) begin
        addr_q <= addr_q + 1'b1;
        if (!unb_q) cnt_q <= cnt_q - 1'b1;
        full_q <= en_q;
      end else begin
        if (deliver_c || !en_q) full_q <= 1'b0;
        if (reg_we_i && !lock_c) begin
          unique case (sel_c)
            SEL_HADDR_LO: addr_q[7:0]    <= reg_wdata_i;
            SEL_HADDR_HI: addr_q[AW-1:8] <= reg_wdata_i[AW-9:0];
            SEL_CNT_LO:   cnt_q[7:0]     <= reg_wdata_i;
            SEL_CTRL: begin
              cnt_q[CW-1:8] <= reg_wdata_i[CW-9:0];
              fast_q        <= reg_wdata_i[CTRL_FAST_BIT];
            end
            default: ;
          endcase
        end
      end

      if (finish_c) en_q <= 1'b0;
      else if (wr_ctrl_c && !reg_wdata_i[CTRL_EN_BIT]) en_q <= 1'b0;
      else if (en_rise_c) en_q <= 1'b1;

      if (en_rise_c) unb_q <= (new_cnt_c == '0);

      if (finish_c) cmp_q <= 1'b1;
      else if (en_rise_c || sts_clr_c) cmp_q <= 1'b0;

      dreq_q <= en_q && full_q && dack_ni && !deliver_c;
    end
  end

  assign addr_o     = addr_q;
  assign fast_o     = fast_q;
  assign lock_o     = lock_c;
  assign dreq_o     = dreq_q;
  assign hdata_o    = lat_q;
  assign hdata_oe_o = !dack_ni && !rd_ni;
  assign cmp_o      = cmp_q;
endmodule

// File: rtl/buf_dma_ctrl.sv
module buf_dma_ctrl
  import buf_dma_pkg::*;
#(
  parameter int AW       = 15,
  parameter int CW       = 12,
  parameter int DW       = 8,
  parameter int FAST_LEN = 4,
  parameter int SLOW_LEN = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  output logic          dreq_o,
  input  logic          dack_ni,
  input  logic          rd_ni,
  output logic [DW-1:0] hdata_o,
  output logic          hdata_oe_o,
  output logic          cmp_o,
  input  logic          drv_valid_i,
  input  logic [DW-1:0] drv_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          host_want, host_gnt, drv_gnt, rd_cap, rd_done, wr_done;
  logic          fast, lock, drv_pend, ld_lo, ld_hi;
  logic [AW-1:0] host_addr, drv_addr;

  assign ld_lo = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_DADDR_LO;
  assign ld_hi = reg_we_i && reg_sel_e'(reg_sel_i) == SEL_DADDR_HI;

  buf_dma_host #(.AW(AW), .CW(CW), .DW(DW)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .dack_ni     (dack_ni),
    .rd_ni       (rd_ni),
    .gnt_i       (host_gnt),
    .cap_i       (rd_cap),
    .done_i      (rd_done),
    .mem_rdata_i (mem_rdata_i),
    .want_o      (host_want),
    .addr_o      (host_addr),
    .fast_o      (fast),
    .lock_o      (lock),
    .dreq_o      (dreq_o),
    .hdata_o     (hdata_o),
    .hdata_oe_o  (hdata_oe_o),
    .cmp_o       (cmp_o)
  );

  buf_dma_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drv_valid_i (drv_valid_i),
    .drv_data_i  (drv_data_i),
    .ld_lo_i     (ld_lo),
    .ld_hi_i     (ld_hi),
    .ld_data_i   (reg_wdata_i),
    .lock_i      (lock),
    .gnt_i       (drv_gnt),
    .done_i      (wr_done),
    .pend_o      (drv_pend),
    .addr_o      (drv_addr),
    .wdata_o     (mem_wdata_o)
  );

  buf_dma_seq #(.AW(AW), .FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_i      (fast),
    .drv_req_i   (drv_pend),
    .host_req_i  (host_want),
    .drv_addr_i  (drv_addr),
    .host_addr_i (host_addr),
    .drv_gnt_o   (drv_gnt),
    .host_gnt_o  (host_gnt),
    .rd_cap_o    (rd_cap),
    .rd_done_o   (rd_done),
    .wr_done_o   (wr_done),
    .mem_addr_o  (mem_addr_o),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no)
  );
endmodule

// File: rtl/buf_dma_ctrl_chk.sv
module buf_dma_ctrl_chk #(
  parameter int AW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dack_ni,
  input logic          dreq_o,
  input logic          cmp_o,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic [AW-1:0] mem_addr_o
);
  // R5
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_ni |=> !dreq_o);

  // R6
  oe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |=> (!mem_oe_no ##1 mem_oe_no));

  // R7
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |=> (!mem_we_no ##1 mem_we_no));

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> $stable(mem_addr_o));

  // R3
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_o) |-> !dreq_o);
endmodule

bind buf_dma_ctrl buf_dma_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dack_ni    (dack_ni),
  .dreq_o     (dreq_o),
  .cmp_o      (cmp_o),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_addr_o (mem_addr_o)
);

// File: tb/buf_dma_ctrl_test.sv
module buf_dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dreq, hdata_oe, cmp;
  logic        dack_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  hdata;
  logic        drv_valid = 1'b0;
  logic [7:0]  drv_data = '0;
  logic [14:0] mem_addr;
  logic        mem_oe_n, mem_we_n;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [int];
  logic [7:0]  exp_q [$];
  int checks = 0, errors = 0;
  int delivered = 0, target = 0;

  always #10 clk = ~clk;

  buf_dma_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .dreq_o(dreq), .dack_ni(dack_n), .rd_ni(rd_n),
    .hdata_o(hdata), .hdata_oe_o(hdata_oe), .cmp_o(cmp),
    .drv_valid_i(drv_valid), .drv_data_i(drv_data), .mem_addr_o(mem_addr),
    .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b1, a[14:8]};
  endfunction

  function automatic logic [7:0] peek(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : pat(a);
  endfunction

  // behavioural SRAM
  always @(posedge clk) if (!mem_we_n) mem[int'(mem_addr)] = mem_wdata;
  always @(negedge clk) mem_rdata = peek(mem_addr);

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", delivered, target);
    finish_sim();
  end

  // host agent: monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (dreq && delivered < target) begin
        dack_n = 1'b0;
        @(negedge clk);
        check(!dreq, "R5 dreq after ack", int'(dreq), 0);
        rd_n = 1'b0;
        #1;
        check(hdata_oe, "R5 data enable", int'(hdata_oe), 1);
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", int'(hdata), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(hdata == e, "R2 byte value", int'(hdata), int'(e));
        end
        @(negedge clk);
        rd_n = 1'b1;
        dack_n = 1'b1;
        delivered++;
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: program a transfer and push expected bytes
  task automatic arm(input logic [14:0] a, input int n, input int push, input bit fast,
                     input bit go);
    wr(3'd0, a[7:0]);
    wr(3'd1, {1'b0, a[14:8]});
    wr(3'd2, n[7:0]);
    for (int i = 0; i < push; i++) exp_q.push_back(peek(a + 15'(i)));
    target += push;
    if (go) wr(3'd3, {1'b1, fast, 2'b00, n[11:8]});
  endtask

  task automatic wait_cmp(input string what);
    for (int i = 0; i < 5000 && !cmp; i++) @(negedge clk);
    check(cmp, what, int'(cmp), 1);
  endtask

  task automatic latency(input bit fast, input int expn, input logic [14:0] a);
    int n;
    arm(a, 1, 1, fast, 1'b1);
    n = 0;
    while (!dreq && n < 100) begin @(negedge clk); n++; end
    check(n == expn, fast ? "R6 fast latency" : "R6 slow latency", n, expn);
    wait_cmp("R3 complete after one byte");
    wr(3'd6, 8'h01);
    #1 check(!cmp, "R10 status clear", int'(cmp), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!dreq, "R1 dreq reset", int'(dreq), 0);
    check(!cmp, "R1 cmp reset", int'(cmp), 0);
    check(mem_oe_n && mem_we_n, "R1 strobes reset", int'({mem_oe_n, mem_we_n}), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    latency(1'b1, 6, 15'h0010);
    latency(1'b0, 14, 15'h0020);

    // bounded across the top of the address space
    arm(15'h7FFD, 5, 5, 1'b1, 1'b1);
    wait_cmp("R3 bounded complete");
    repeat (30) @(negedge clk);
    check(delivered == target, "R3 byte total", delivered, target);
    check(!dreq, "R3 quiet after done", int'(dreq), 0);
    check(exp_q.size() == 0, "R2 wrap queue drained", exp_q.size(), 0);

    // unbounded with drive bytes and blocked reloads
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h03);
    arm(15'h0500, 0, 40, 1'b0, 1'b1);
    check(!cmp, "R10 enable clears status", int'(cmp), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drv_valid = 1'b1; drv_data = 8'hA0 + 8'(i);
      @(negedge clk);
      drv_valid = 1'b0;
      repeat (30) @(negedge clk);
    end
    wr(3'd0, 8'h00);   // R9 ignored while enabled
    wr(3'd4, 8'h77);   // R9 ignored while enabled
    for (int i = 0; i < 5000 && delivered < target; i++) @(negedge clk);
    wr(3'd3, 8'h00);
    @(negedge clk);
    check(!dreq, "R4 stop on disable", int'(dreq), 0);
    check(!cmp, "R4 no completion", int'(cmp), 0);
    check(exp_q.size() == 0 && delivered == target, "R9 stream intact", exp_q.size(), 0);
    repeat (20) @(negedge clk);

    // read back the drive bytes
    for (int i = 0; i < 4; i++) begin
      check(peek(15'h0300 + 15'(i)) == 8'hA0 + 8'(i), "R7 stored drive byte",
            int'(peek(15'h0300 + 15'(i))), int'(8'hA0 + 8'(i)));
    end
    arm(15'h0300, 4, 4, 1'b1, 1'b1);
    wait_cmp("R7 read-back complete");
    check(exp_q.size() == 0, "R7 read-back drained", exp_q.size(), 0);

    // drive byte and host enable in the same clock
    arm(15'h0600, 1, 1, 1'b1, 1'b0);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 8'hC0;
    drv_valid = 1'b1; drv_data = 8'h5C;
    @(negedge clk);
    reg_we = 1'b0; drv_valid = 1'b0;
    for (int i = 0; i < 50 && mem_oe_n && mem_we_n; i++) @(negedge clk);
    check(!mem_we_n && mem_oe_n, "R8 write first", int'({mem_oe_n, mem_we_n}), 2);
    wait_cmp("R8 host read after write");
    check(peek(15'h0304) == 8'h5C, "R7 address advanced", int'(peek(15'h0304)), 8'h5C);
    check(exp_q.size() == 0 && delivered == target, "R8 host byte", delivered, target);

    finish_sim();
  end
endmodule